// File: doc/BRIEF.md
# Reference Selection and Operating Mode Controller

This block picks which of three timing references a synchronizer follows and decides the synchronizer's operating mode: freerun, normal, holdover, or a one-cycle phase-offset capture state that sits between holdover (or freerun) and normal. It takes a 2-bit mode select, a 2-bit manual reference select, one fail flag per reference, a hitless-recovery control and the raw lock indication of the loop. It returns the active reference index, the mode, a holdover flag, a capture enable for the phase-offset corrector, a strobe that restarts lock qualification, and a qualified lock output.

In manual operation the reference select picks the input directly. In automatic operation only references 0 and 1 are candidates. The choice does not revert to reference 0 on its own, except when automatic operation starts while reference 2 is active. Whenever the active index moves, lock qualification restarts from zero. Whenever the index moves inside normal mode, the corrector is told to capture the new phase offset so that the switch is hitless.

Top module: `refsel_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, mode_o is 00 (freerun), ref_o is 0, and holdover_o, tie_cap_o, lock_rst_o and lock_o are all 0.
- R2: When mode_sel_i is not 11, the ref_sel_i value in the current cycle is the target, and ref_o shows it one clock later. Values 0, 1 and 2 select that reference, and value 3 selects reference 2.
- R3: When mode_sel_i is 11, ref_o only takes the values 0 or 1. The active reference is kept while its fail flag is low. If it fails and the other candidate is good, ref_o moves to the other candidate one clock later. If both have failed, ref_o is unchanged and the mode becomes holdover.
- R4: When mode_sel_i is 11 and ref_o is 2, the next ref_o is 0 if ref_fail_i[0] is low, otherwise 1 if ref_fail_i[1] is low, otherwise it stays 2.
- R5: In normal mode (01), a high fail flag on the target reference moves the mode to holdover (10) one clock later, with holdover_o high exactly while mode_o is 10.
- R6: From freerun or holdover, a good target with hms_i low moves the mode directly to normal one clock later, with no tie_cap_o pulse.
- R7: From freerun or holdover, a good target with hms_i high moves the mode to the capture state (11) for exactly one cycle, with tie_cap_o high in that cycle. The mode then goes to normal, or to holdover if the target has failed by then.
- R8: A change of active reference while the mode is normal before and after the clock produces a one-cycle tie_cap_o pulse in the cycle the new ref_o appears.
- R9: Every change of ref_o is accompanied by a one-cycle lock_rst_o pulse in the same cycle, and lock_o is low from that cycle on until lock has been requalified.
- R10: lock_o is high only after lock_i has been high on LOCK_QUAL_CYCLES consecutive clocks since the last reference change. It goes low one clock after lock_i is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_sel_i | input | 2 | 11 = automatic selection, other values = manual selection |
| ref_sel_i | input | 2 | Manual reference choice (3 treated as 2) |
| ref_fail_i | input | 3 | Per-reference fail flags, bit n for reference n |
| hms_i | input | 1 | High: recover through the phase-capture state; low: realign directly |
| lock_i | input | 1 | Raw lock indication from the loop |
| ref_o | output | 2 | Active reference index |
| mode_o | output | 2 | 00 freerun, 01 normal, 10 holdover, 11 phase capture |
| holdover_o | output | 1 | High while in holdover |
| tie_cap_o | output | 1 | One-cycle phase-offset capture enable |
| lock_rst_o | output | 1 | One-cycle strobe restarting lock qualification |
| lock_o | output | 1 | Qualified lock |

## Verification
Directed sequences take the controller out of freerun, and out of holdover, with both settings of hms_i, to tell the direct path from the capture path. Manual switches are made both in normal mode and in holdover, which separates a capture pulse caused by a switch from one caused by recovery. The automatic sequences enter from reference 2, fail the active reference with the other one good, restore it to show that the choice does not revert, and then fail both. Long stretches of random select, fail and lock patterns are then compared cycle by cycle against a behavioural model, which exercises requalification being cut short by switches and by lock dropouts.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned NUM_REF = 3;
  localparam int unsigned REF_W   = $clog2(NUM_REF);
  localparam logic [1:0]  AUTO_SEL = 2'b11;

  typedef enum logic [1:0] {
    MODE_FREE = 2'b00,
    MODE_NORM = 2'b01,
    MODE_HOLD = 2'b10,
    MODE_TIE  = 2'b11
  } op_mode_e;
endpackage

// File: rtl/refsel_pick.sv
module refsel_pick
  import refsel_pkg::*;
(
  input  logic [1:0]       mode_sel_i,
  input  logic [1:0]       ref_sel_i,
  input  logic [NUM_REF-1:0] ref_fail_i,
  input  logic [REF_W-1:0] act_i,
  output logic [REF_W-1:0] tgt_o,
  output logic             tgt_ok_o
);
  logic [REF_W-1:0] man_ref, cur_ref, oth_ref;

  // manual: code 3 folds onto the last reference
  assign man_ref = (ref_sel_i > REF_W'(NUM_REF-1)) ? REF_W'(NUM_REF-1) : ref_sel_i;

  // automatic: only 0/1; leaving 2 starts from 0
  assign cur_ref = (act_i == REF_W'(0) || act_i == REF_W'(1)) ? act_i : REF_W'(0);
  assign oth_ref = (cur_ref == REF_W'(0)) ? REF_W'(1) : REF_W'(0);

  always_comb begin
    if (mode_sel_i != AUTO_SEL) begin
      tgt_o = man_ref;
    end else if (!ref_fail_i[cur_ref]) begin
      tgt_o = cur_ref;
    end else if (!ref_fail_i[oth_ref]) begin
      tgt_o = oth_ref;
    end else begin
      tgt_o = act_i;
    end
  end

  assign tgt_ok_o = !ref_fail_i[tgt_o];
endmodule

// File: rtl/refsel_fsm.sv
module refsel_fsm
  import refsel_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REF_W-1:0] tgt_i,
  input  logic             tgt_ok_i,
  input  logic             hms_i,
  output logic [REF_W-1:0] act_o,
  output op_mode_e         mode_o,
  output logic             tie_cap_o,
  output logic             lock_rst_o,
  output logic             switch_o
);
  op_mode_e         state_q, state_d;
  logic [REF_W-1:0] act_q;
  logic             tie_q, lrst_q, tie_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MODE_FREE, MODE_HOLD: if (tgt_ok_i) state_d = hms_i ? MODE_TIE : MODE_NORM;
      MODE_NORM:            if (!tgt_ok_i) state_d = MODE_HOLD;
      MODE_TIE:             state_d = tgt_ok_i ? MODE_NORM : MODE_HOLD;
      default:              state_d = MODE_FREE;
    endcase
  end

  assign switch_o = (tgt_i != act_q);
  // capture on entry to TIE, or on a switch that stays in normal
  assign tie_d = (state_d == MODE_TIE) ||
                 (state_q == MODE_NORM && state_d == MODE_NORM && switch_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MODE_FREE;
      act_q   <= '0;
      tie_q   <= 1'b0;
      lrst_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= tgt_i;
      tie_q   <= tie_d;
      lrst_q  <= switch_o;
    end
  end

  assign act_o      = act_q;
  assign mode_o     = state_q;
  assign tie_cap_o  = tie_q;
  assign lock_rst_o = lrst_q;
endmodule

// File: rtl/refsel_lockq.sv
module refsel_lockq #(
  parameter int unsigned QUAL_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lock_i,
  output logic lock_o
);
  localparam int unsigned CNT_W = $clog2(QUAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(QUAL_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || !lock_i)    cnt_q <= '0;
    else if (cnt_q != CNT_MAX)    cnt_q <= cnt_q + 1'b1;
  end

  assign lock_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/refsel_ctrl.sv
module refsel_ctrl
  import refsel_pkg::*;
#(
  parameter int unsigned LOCK_QUAL_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       mode_sel_i,
  input  logic [1:0]       ref_sel_i,
  input  logic [NUM_REF-1:0] ref_fail_i,
  input  logic             hms_i,
  input  logic             lock_i,
  output logic [REF_W-1:0] ref_o,
  output logic [1:0]       mode_o,
  output logic             holdover_o,
  output logic             tie_cap_o,
  output logic             lock_rst_o,
  output logic             lock_o
);
  logic [REF_W-1:0] tgt, act;
  logic             tgt_ok, sw;
  op_mode_e         mode;

  refsel_pick u_pick (
    .mode_sel_i (mode_sel_i),
    .ref_sel_i  (ref_sel_i),
    .ref_fail_i (ref_fail_i),
    .act_i      (act),
    .tgt_o      (tgt),
    .tgt_ok_o   (tgt_ok)
  );

  refsel_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tgt_i      (tgt),
    .tgt_ok_i   (tgt_ok),
    .hms_i      (hms_i),
    .act_o      (act),
    .mode_o     (mode),
    .tie_cap_o  (tie_cap_o),
    .lock_rst_o (lock_rst_o),
    .switch_o   (sw)
  );

  refsel_lockq #(.QUAL_CYCLES(LOCK_QUAL_CYCLES)) u_lockq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (sw),
    .lock_i (lock_i),
    .lock_o (lock_o)
  );

  assign ref_o      = act;
  assign mode_o     = mode;
  assign holdover_o = (mode == MODE_HOLD);
endmodule

// File: rtl/refsel_ctrl_chk.sv
module refsel_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_sel_i,
  input logic       hms_i,
  input logic [1:0] ref_o,
  input logic [1:0] mode_o,
  input logic       tie_cap_o,
  input logic       lock_rst_o,
  input logic       lock_o
);
  // R7
  tie_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |=> (mode_o != 2'b11));

  // R7
  tie_cap_in_tie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'b11) |-> tie_cap_o);

  // R9
  switch_restarts_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_o != $past(ref_o)) |-> (lock_rst_o && !lock_o));

  // R6
  direct_needs_hms_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(mode_o) == 2'b10 || $past(mode_o) == 2'b00) && mode_o == 2'b01) |-> !$past(hms_i));

  // R3
  auto_no_third_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_sel_i == 2'b11 && $past(mode_sel_i) == 2'b11 && $past(ref_o) != 2'd2) |-> (ref_o != 2'd2));
endmodule

bind refsel_ctrl refsel_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mode_sel_i (mode_sel_i),
  .hms_i      (hms_i),
  .ref_o      (ref_o),
  .mode_o     (mode_o),
  .tie_cap_o  (tie_cap_o),
  .lock_rst_o (lock_rst_o),
  .lock_o     (lock_o)
);

// File: tb/refsel_ctrl_tb_top.sv
module refsel_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00, ref_sel = 2'b00;
  logic [2:0] ref_fail = 3'b111;
  logic       hms = 1'b0, lock_in = 1'b0;
  logic [1:0] ref_o, mode_o;
  logic       holdover_o, tie_cap_o, lock_rst_o, lock_o;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  refsel_ctrl #(.LOCK_QUAL_CYCLES(QUAL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mode_sel_i(mode_sel), .ref_sel_i(ref_sel),
    .ref_fail_i(ref_fail), .hms_i(hms), .lock_i(lock_in),
    .ref_o(ref_o), .mode_o(mode_o), .holdover_o(holdover_o),
    .tie_cap_o(tie_cap_o), .lock_rst_o(lock_rst_o), .lock_o(lock_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model: mode 0 free,1 norm,2 hold,3 tie
  int m_mode = 0, m_ref = 0, m_tie = 0, m_lrst = 0, m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_ref = 0; m_tie = 0; m_lrst = 0; m_cnt = 0;
    end else begin
      int tgt, cur, oth, nxt;
      bit ok, sw;
      if (mode_sel != 2'b11) tgt = (ref_sel == 3) ? 2 : int'(ref_sel);
      else begin
        cur = (m_ref == 2) ? 0 : m_ref;
        oth = 1 - cur;
        if (!ref_fail[cur]) tgt = cur;
        else if (!ref_fail[oth]) tgt = oth;
        else tgt = m_ref;
      end
      ok = !ref_fail[tgt];
      nxt = m_mode;
      if (m_mode == 0 || m_mode == 2) begin if (ok) nxt = hms ? 3 : 1; end
      else if (m_mode == 1) begin if (!ok) nxt = 2; end
      else nxt = ok ? 1 : 2;
      sw = (tgt != m_ref);
      m_tie = (nxt == 3 || (m_mode == 1 && nxt == 1 && sw)) ? 1 : 0;
      m_lrst = sw ? 1 : 0;
      if (sw || !lock_in) m_cnt = 0;
      else if (m_cnt < QUAL) m_cnt++;
      m_ref = tgt;
      m_mode = nxt;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    cmp("ref_o", int'(ref_o), m_ref);
    cmp("mode_o", int'(mode_o), m_mode);
    cmp("holdover_o", int'(holdover_o), (m_mode == 2) ? 1 : 0);
    cmp("tie_cap_o", int'(tie_cap_o), m_tie);
    cmp("lock_rst_o", int'(lock_rst_o), m_lrst);
    cmp("lock_o", int'(lock_o), (m_cnt == QUAL) ? 1 : 0);
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    step(3);
    tag = "R1";
    cmp("reset mode", int'(mode_o), 0);
    cmp("reset ref", int'(ref_o), 0);
    rst_n = 1'b1;
    step(1);
    cmp("post-reset lock", int'(lock_o), 0);
    cmp("post-reset holdover", int'(holdover_o), 0);
    step(2);

    tag = "R6"; hms = 0; lock_in = 1; ref_fail = 3'b110;
    step(1);
    cmp("direct to normal", int'(mode_o), 1);
    cmp("no capture", int'(tie_cap_o), 0);
    tag = "R10"; step(QUAL + 2);
    cmp("lock after qualify", int'(lock_o), 1);

    tag = "R8"; ref_sel = 2'd1; ref_fail = 3'b100;
    step(1);
    cmp("switch capture", int'(tie_cap_o), 1);
    tag = "R9";
    cmp("lock restart", int'(lock_rst_o), 1);
    cmp("lock dropped", int'(lock_o), 0);
    step(QUAL + 2);

    tag = "R5"; ref_fail = 3'b110;
    step(1);
    cmp("holdover entered", int'(mode_o), 2);
    step(3);
    tag = "R7"; hms = 1; ref_fail = 3'b000;
    step(1);
    cmp("capture state", int'(mode_o), 3);
    cmp("capture pulse", int'(tie_cap_o), 1);
    step(1);
    cmp("then normal", int'(mode_o), 1);
    step(3);

    tag = "R2"; ref_sel = 2'd2; step(3);
    ref_sel = 2'd3; step(1);
    cmp("code 3 gives 2", int'(ref_o), 2);
    step(2);

    tag = "R4"; mode_sel = 2'b11;
    step(1);
    cmp("auto from 2 picks 0", int'(ref_o), 0);
    step(3);

    tag = "R3"; ref_fail = 3'b001; step(1);
    cmp("fail over to 1", int'(ref_o), 1);
    step(2); ref_fail = 3'b000; step(3);
    cmp("non-revertive", int'(ref_o), 1);
    ref_fail = 3'b011; step(1);
    cmp("both failed holdover", int'(holdover_o), 1);
    cmp("both failed keep ref", int'(ref_o), 1);
    hms = 0; ref_fail = 3'b010; step(1);
    cmp("recover on 0", int'(ref_o), 0);
    step(3);

    tag = "R10";
    for (int i = 0; i < 40; i++) begin lock_in = (i % 7) != 3; step(1); end
    lock_in = 1;

    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      mode_sel = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
      if ($urandom % 4 == 0) ref_sel = 2'($urandom);
      if ($urandom % 5 == 0) ref_fail = 3'($urandom);
      if ($urandom % 6 == 0) hms = 1'($urandom);
      lock_in = ($urandom % 16) != 0;
      step(1 + ($urandom % 3));
    end
    step(2);
    finish_run();
  end
endmodule